// File: doc/BRIEF.md
# Grouped Level Interrupt Combiner

The combiner gathers many level-sensitive peripheral interrupt lines into groups of eight and drives one summary interrupt per group toward an upstream interrupt controller. A group's summary is high while at least one of its eight lines is high and also enabled. Each summary is taken from a flip-flop, so it cannot glitch when source lines or enables change together.

Software reaches the block over a simple word-aligned register bus. Four consecutive groups share one register bank, and the bank is 32 bits wide. Group `g` owns the byte slice `[(g mod 4)*8 +: 8]` of bank `g/4`, and bank `k` is based at byte offset `k*0x10`. Each bank has three registers:
- offset 0x0: write-one-to-enable.
- offset 0x4: write-one-to-disable.
- offset 0xC: read-only live status. A status bit equals `line AND enable`.

Because enables change only through these set and clear strobes, software never needs a read-modify-write. The interrupt handler finds the pending source by taking the lowest set bit of the group's status slice.

A small two-state bus machine drives the read path:
- **IDLE**: no read data is presented.
- **RESPOND**: the captured word is presented with `bus_rvalid` high.

The transitions are:
- IDLE→RESPOND on a read accept.
- RESPOND→RESPOND on a back-to-back read.
- RESPOND→IDLE when no read is presented.

Writes complete in a single cycle in either state.

Top module: `grp_irq_combiner`

## Requirements
- R1: `irq_out[g]` is 1 exactly when some bit of `src_lines[g*8 +: 8]` AND the matching enable bits was 1 at the previous rising clock edge.
- R2: Line `i` of group `g` maps to bit `(g mod 4)*8 + i` of bank `g/4`. Bank `k`'s registers sit at byte address `k*0x10` plus the register offset.
- R3: A write to offset 0x0 sets every enable bit whose data bit is 1 and leaves the bits whose data bit is 0 unchanged.
- R4: A write to offset 0x4 clears every enable bit whose data bit is 1 and leaves the bits whose data bit is 0 unchanged.
- R5: A read of offset 0xC returns `src_lines AND enables` for the bank, with no latching. Writes to 0xC change nothing.
- R6: A read of offset 0x0 or of offset 0x4 returns the bank's current enable bits.
- R7: Reset has the following effects:
  - all enable bits become 0;
  - `irq_out` becomes all 0;
  - `bus_rvalid` becomes 0.
- R8: These addresses read as zero and are ignored on write:
  - any bank at or beyond `NUM_GROUPS/4`;
  - offset 0x8 of any bank.
- R9: A read accepted at a rising edge (`bus_sel`=1, `bus_wr`=0) presents `bus_rvalid`=1 and its data in the following cycle. Without a read accept, `bus_rvalid` is 0 in the following cycle.
- R10: A change on a source line or on an enable bit reaches `irq_out` one clock edge later, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lines | input | NUM_GROUPS*8 | Level interrupt sources, eight per group |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rvalid is 1 |
| bus_rvalid | output | 1 | Read response valid |
| irq_out | output | NUM_GROUPS | One registered summary interrupt per group |

## Verification
A write takes effect at the rising edge where it is accepted. A read gives its data one cycle after it is accepted. A group summary follows its lines and enables one edge later. Enable changes therefore appear on `irq_out` two edges after the write is presented.

The bench drives all inputs on falling edges and samples on falling edges. It checks a summary at the first falling edge after the edge that registers it. It also probes just after a source change to confirm the summary has not yet moved. Read data is sampled at the falling edge that follows the accepting rising edge, together with `bus_rvalid`.

// File: rtl/irq_comb_pkg.sv
package irq_comb_pkg;
    localparam int LINES_PER_GROUP = 8;
    localparam int GROUPS_PER_BANK = 4;
    localparam int BANK_W          = LINES_PER_GROUP * GROUPS_PER_BANK;
    localparam int BANK_STRIDE_LG2 = 4;  // banks spaced 0x10 apart

    // register select taken from address bits [3:2]
    typedef enum logic [1:0] {
        REG_EN_SET = 2'd0,
        REG_EN_CLR = 2'd1,
        REG_RSVD   = 2'd2,
        REG_STATUS = 2'd3
    } reg_sel_e;

    typedef enum logic {
        BUS_IDLE    = 1'b0,
        BUS_RESPOND = 1'b1
    } bus_state_e;
endpackage

// File: rtl/irq_comb_bus_fsm.sv
module irq_comb_bus_fsm
    import irq_comb_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_BANKS = 2,
    localparam int BIDX_W   = ADDR_W - BANK_STRIDE_LG2,
    localparam int FLAT_W   = NUM_BANKS * BANK_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [FLAT_W-1:0]    en_flat,
    input  logic [FLAT_W-1:0]    stat_flat,
    output logic [NUM_BANKS-1:0] set_we,
    output logic [NUM_BANKS-1:0] clr_we,
    output logic [BANK_W-1:0]    bus_rdata,
    output logic                 bus_rvalid
);
    bus_state_e         state_q, state_d;
    logic [BIDX_W-1:0]  bank_idx;
    reg_sel_e           reg_sel;
    logic               rd_accept;
    logic [BANK_W-1:0]  rd_value;
    logic [BANK_W-1:0]  rdata_q;
    logic [1:0]         unused_addr_lsb;

    assign bank_idx        = bus_addr[ADDR_W-1:BANK_STRIDE_LG2];
    assign reg_sel         = reg_sel_e'(bus_addr[3:2]);
    assign unused_addr_lsb = bus_addr[1:0];
    assign rd_accept       = bus_sel && !bus_wr;

    // per-bank write strobes and read mux; unmatched banks give zero
    always_comb begin
        rd_value = '0;
        set_we   = '0;
        clr_we   = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_idx == BIDX_W'(b)) begin
                set_we[b] = bus_sel && bus_wr && (reg_sel == REG_EN_SET);
                clr_we[b] = bus_sel && bus_wr && (reg_sel == REG_EN_CLR);
                unique case (reg_sel)
                    REG_EN_SET,
                    REG_EN_CLR: rd_value = en_flat[b*BANK_W +: BANK_W];
                    REG_STATUS: rd_value = stat_flat[b*BANK_W +: BANK_W];
                    REG_RSVD:   rd_value = '0;
                endcase
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE:    if (rd_accept) state_d = BUS_RESPOND;
            BUS_RESPOND: state_d = rd_accept ? BUS_RESPOND : BUS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         rdata_q <= '0;
        else if (rd_accept) rdata_q <= rd_value;
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = (state_q == BUS_RESPOND);
endmodule

// File: rtl/irq_comb_bank.sv
module irq_comb_bank
    import irq_comb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic [BANK_W-1:0] wdata,
    input  logic [BANK_W-1:0] src,
    output logic [BANK_W-1:0] en,
    output logic [BANK_W-1:0] status
);
    logic [BANK_W-1:0] en_q;
    logic [BANK_W-1:0] set_mask;
    logic [BANK_W-1:0] clr_mask;

    assign set_mask = set_we ? wdata : '0;
    assign clr_mask = clr_we ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= (en_q | set_mask) & ~clr_mask;
    end

    assign en     = en_q;
    assign status = src & en_q;
endmodule

// File: rtl/irq_comb_group_out.sv
module irq_comb_group_out
    import irq_comb_pkg::*;
#(
    parameter int NUM_GROUPS = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [NUM_GROUPS*LINES_PER_GROUP-1:0] status_flat,
    output logic [NUM_GROUPS-1:0]                 irq
);
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq[g] <= 1'b0;
            else        irq[g] <= |status_flat[g*LINES_PER_GROUP +: LINES_PER_GROUP];
        end
    end
endmodule

// File: rtl/grp_irq_combiner.sv
module grp_irq_combiner
    import irq_comb_pkg::*;
#(
    parameter int NUM_GROUPS = 8,   // must be a multiple of GROUPS_PER_BANK
    parameter int ADDR_W     = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [NUM_GROUPS*LINES_PER_GROUP-1:0] src_lines,
    input  logic                                  bus_sel,
    input  logic                                  bus_wr,
    input  logic [ADDR_W-1:0]                     bus_addr,
    input  logic [BANK_W-1:0]                     bus_wdata,
    output logic [BANK_W-1:0]                     bus_rdata,
    output logic                                  bus_rvalid,
    output logic [NUM_GROUPS-1:0]                 irq_out
);
    localparam int NUM_BANKS = NUM_GROUPS / GROUPS_PER_BANK;
    localparam int FLAT_W    = NUM_BANKS * BANK_W;

    logic [NUM_BANKS-1:0] set_we;
    logic [NUM_BANKS-1:0] clr_we;
    logic [FLAT_W-1:0]    en_flat;
    logic [FLAT_W-1:0]    stat_flat;

    irq_comb_bus_fsm #(
        .ADDR_W    (ADDR_W),
        .NUM_BANKS (NUM_BANKS)
    ) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .en_flat    (en_flat),
        .stat_flat  (stat_flat),
        .set_we     (set_we),
        .clr_we     (clr_we),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        irq_comb_bank u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_we (set_we[b]),
            .clr_we (clr_we[b]),
            .wdata  (bus_wdata),
            .src    (src_lines[b*BANK_W +: BANK_W]),
            .en     (en_flat[b*BANK_W +: BANK_W]),
            .status (stat_flat[b*BANK_W +: BANK_W])
        );
    end

    irq_comb_group_out #(
        .NUM_GROUPS (NUM_GROUPS)
    ) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .status_flat (stat_flat),
        .irq         (irq_out)
    );
endmodule

// File: rtl/grp_irq_combiner_chk.sv
module grp_irq_combiner_chk
    import irq_comb_pkg::*;
#(
    parameter int NUM_GROUPS = 8,
    parameter int ADDR_W     = 8,
    localparam int NUM_BANKS = NUM_GROUPS / GROUPS_PER_BANK
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic [NUM_GROUPS*LINES_PER_GROUP-1:0] src_lines,
    input logic                                  bus_sel,
    input logic                                  bus_wr,
    input logic [ADDR_W-1:0]                     bus_addr,
    input logic [BANK_W-1:0]                     bus_wdata,
    input logic [BANK_W-1:0]                     bus_rdata,
    input logic                                  bus_rvalid,
    input logic [NUM_GROUPS-1:0]                 irq_out,
    input logic [NUM_BANKS*BANK_W-1:0]           en_flat
);
    // R7: outputs held quiet while reset is applied
    always @(negedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R7: assert (irq_out == '0 && !bus_rvalid);
        end
    end

    // R1: a group with no active lines or no enables is low next cycle
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp_chk
        assert_idle_src_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (src_lines[g*LINES_PER_GROUP +: LINES_PER_GROUP] == '0) |=> !irq_out[g]);
        assert_idle_en_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (en_flat[g*LINES_PER_GROUP +: LINES_PER_GROUP] == '0) |=> !irq_out[g]);
    end

    // R3: bank 0 set write turns on every written one
    assert_set_applies_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(0))
        |=> ((en_flat[BANK_W-1:0] & $past(bus_wdata)) == $past(bus_wdata)));

    // R4: bank 0 clear write turns off every written one
    assert_clear_applies_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(4))
        |=> ((en_flat[BANK_W-1:0] & $past(bus_wdata)) == '0));

    // R9: read response timing
    assert_rvalid_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |=> bus_rvalid);
    assert_no_rvalid_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> !bus_rvalid);

    // R8: unimplemented bank reads zero
    assert_unimpl_bank_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && (int'(bus_addr >> BANK_STRIDE_LG2) >= NUM_BANKS))
        |=> (bus_rdata == '0));
endmodule

bind grp_irq_combiner grp_irq_combiner_chk #(
    .NUM_GROUPS (NUM_GROUPS),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_lines  (src_lines),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .irq_out    (irq_out),
    .en_flat    (en_flat)
);

// File: tb/test_grp_irq_combiner.sv
module test_grp_irq_combiner;
    localparam int NG = 8;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NG*8-1:0] src_lines = '0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid;
    logic [NG-1:0] irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    grp_irq_combiner #(.NUM_GROUPS(NG), .ADDR_W(AW)) i_grp_irq_combiner (
        .clk(clk), .rst_n(rst_n), .src_lines(src_lines),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .irq_out(irq_out)
    );

    typedef struct packed {
        logic [31:0] en0;
        logic [31:0] en1;
        logic [63:0] src;   // {bank1 lines, bank0 lines}
        logic [7:0]  irq;
        logic [31:0] st0;
        logic [31:0] st1;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{32'h0000_0000, 32'h0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00, 32'h0000_0000, 32'h0000_0000},
        '{32'h0000_00FF, 32'h0000_0000, 64'h0000_0000_0000_0010, 8'h01, 32'h0000_0010, 32'h0000_0000},
        '{32'hFF00_FF00, 32'h0000_000F, 64'h0000_00F0_0100_0100, 8'h0A, 32'h0100_0100, 32'h0000_0000},
        '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'h0100_0000_8040_2000, 8'h8E, 32'h8040_2000, 32'h0100_0000},
        '{32'h00FF_0000, 32'h00FF_0000, 64'h0080_0000_FF00_FFFF, 8'h40, 32'h0000_0000, 32'h0080_0000}
    };

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata; v = bus_rvalid;
        bus_sel = 1'b0;
    endtask

    task automatic read_check(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
        logic [31:0] d;
        logic v;
        bus_read(a, d, v);
        check("R9", "rvalid on read", {63'd0, v}, 64'd1);
        check(req, $sformatf("read 0x%02h", a), {32'd0, d}, {32'd0, exp});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R7: reset state
        repeat (3) @(negedge clk);
        check("R7", "irq in reset", {56'd0, irq_out}, 64'd0);
        check("R7", "rvalid in reset", {63'd0, bus_rvalid}, 64'd0);
        rst_n = 1'b1;
        read_check("R7", 8'h00, 32'h0);
        read_check("R7", 8'h10, 32'h0);
        @(negedge clk);
        check("R9", "rvalid after read ends", {63'd0, bus_rvalid}, 64'd0);

        // R1 R2 R5 R6: vector walk
        foreach (VECS[i]) begin
            src_lines = VECS[i].src;
            bus_write(8'h04, 32'hFFFF_FFFF);
            bus_write(8'h14, 32'hFFFF_FFFF);
            bus_write(8'h00, VECS[i].en0);
            bus_write(8'h10, VECS[i].en1);
            @(negedge clk);
            check("R1", $sformatf("irq vec %0d", i), {56'd0, irq_out}, {56'd0, VECS[i].irq});
            read_check("R5", 8'h0C, VECS[i].st0);
            read_check("R2", 8'h1C, VECS[i].st1);
            read_check("R6", 8'h00, VECS[i].en0);
            read_check("R6", 8'h14, VECS[i].en1);
        end

        // R10: one-edge latency on source change
        src_lines = '0;
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_write(8'h14, 32'hFFFF_FFFF);
        bus_write(8'h00, 32'h0000_0001);
        @(negedge clk);
        src_lines[0] = 1'b1;
        #1;
        check("R10", "irq before edge", {63'd0, irq_out[0]}, 64'd0);
        @(negedge clk);
        check("R10", "irq after edge", {63'd0, irq_out[0]}, 64'd1);
        src_lines[0] = 1'b0;
        #1;
        check("R10", "irq holds before edge", {63'd0, irq_out[0]}, 64'd1);
        @(negedge clk);
        check("R10", "irq drops after edge", {63'd0, irq_out[0]}, 64'd0);

        // R3 R4: write-zero has no effect, single bits set and clear
        bus_write(8'h00, 32'h0000_00FF);
        bus_write(8'h00, 32'h0000_0000);
        read_check("R3", 8'h00, 32'h0000_00FF);
        bus_write(8'h04, 32'h0000_0000);
        read_check("R4", 8'h04, 32'h0000_00FF);
        bus_write(8'h04, 32'h0000_0001);
        read_check("R4", 8'h00, 32'h0000_00FE);
        bus_write(8'h00, 32'h0000_0100);
        read_check("R3", 8'h00, 32'h0000_01FE);

        // R5: status is read-only and live
        bus_write(8'h0C, 32'hFFFF_FFFF);
        read_check("R5", 8'h00, 32'h0000_01FE);
        src_lines[31:0] = 32'h0000_0106;
        read_check("R5", 8'h0C, 32'h0000_0106);
        src_lines[31:0] = 32'h0000_0000;
        read_check("R5", 8'h0C, 32'h0000_0000);

        // R8: unimplemented bank and reserved offset
        bus_write(8'h20, 32'hFFFF_FFFF);
        bus_write(8'h08, 32'hFFFF_FFFF);
        read_check("R8", 8'h20, 32'h0);
        read_check("R8", 8'h2C, 32'h0);
        read_check("R8", 8'h08, 32'h0);
        read_check("R8", 8'h00, 32'h0000_01FE);
        read_check("R8", 8'h10, 32'h0);

        // R7: reset mid-run clears enables
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        read_check("R7", 8'h00, 32'h0);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule